// File: doc/BRIEF.md
# Post-Increment Word Load/Store Datapath

This block is a single-cycle datapath slice that executes word loads and word stores, together with load and store forms that also step their base register forward by one word. Each instruction arrives as one 32-bit word with a valid strobe and retires on the next rising clock edge. The block holds one 32-entry register file, a small word-addressed data memory, an address adder and a separate base incrementer. The register file has two write ports. The second write port always targets the base register named by the instruction, so a post-increment load can write both the loaded word and the stepped base in the same cycle.

The instruction word is split into four fields. The opcode is in bits [31:26]. The base register index `rs` is in [25:21]. The data register index `rt` is in [20:16]. A signed 16-bit offset is in [15:0]. The effective address is the base register value, taken before any increment, plus the sign-extended offset. Memory is word addressed, so the low two address bits have no effect.

A preload port lets the surrounding logic fill the data memory. Two combinational inspection ports return any register and any memory word, so the final state can be read back.

Top module: `ldinc_core`

## Requirements
- R1: A synchronous reset clears every register to zero. After reset, every register reads back as zero.
- R2: Opcode 0x23 (load) writes `mem[EA]` into `rt` and leaves `rs` unchanged. EA is the base register value plus the sign-extended offset.
- R3: Opcode 0x2B (store) writes the value of `rt` to `mem[EA]` and changes no register.
- R4: Opcode 0x33 (load, post-increment) writes `mem[EA]` into `rt`. In the same cycle it writes `rs + 4` into `rs`.
- R5: Opcode 0x3B (store, post-increment) writes `rt` to `mem[EA]` and writes `rs + 4` into `rs`. It never asserts the primary register write.
- R6: EA is computed from the value of `rs` before the increment, using the sign-extended 16-bit offset, so negative offsets work. EA bits [1:0] are ignored. The memory word index is EA[log2(MEM_WORDS)+1:2], taken modulo the memory size.
- R7: In a post-increment load with `rt == rs`, that register ends up holding the loaded word, not `rs + 4`.
- R8: Writes to register 0 from either port are discarded, and register 0 always reads as zero.
- R9: Any other opcode, or a low valid strobe, changes no register and no memory word.
- R10: Fields are taken from fixed bit positions: opcode [31:26], `rs` [25:21], `rt` [20:16] and offset [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the register file |
| instrValid | input | 1 | Qualifies `instrWord` for this cycle |
| instrWord | input | 32 | Instruction word |
| preWrEn | input | 1 | Memory preload write enable |
| preWrAddr | input | 6 | Preload word index |
| preWrData | input | 32 | Preload data |
| dbgRegAddr | input | 5 | Register inspection index |
| dbgRegData | output | 32 | Register inspection data, combinational |
| dbgMemAddr | input | 6 | Memory inspection word index |
| dbgMemData | output | 32 | Memory inspection data, combinational |

## Verification
Every architectural effect of an instruction lands on the rising edge that samples it. That includes both register writes and the memory write, so all results are due one edge after the instruction is presented. The bench drives each instruction on a falling edge and drops valid on the next falling edge. Only then does it sweep the inspection ports: every register and every memory word is compared against a model computed from the requirements. No edge can alter state during the sweep, because valid and preload are both low. The reset check reads the registers in the first idle period after reset is released.

// File: rtl/ldinc_pkg.sv
package ldinc_pkg;
  typedef struct packed {
    logic regWrite;   // primary port: rt <= memory data
    logic baseWrite;  // second port: rs <= rs + stride
    logic memWrite;   // memory <= rt
  } ctlStrobe_t;

  typedef struct packed {
    logic [5:0]  opcode;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] offset;
  } instrFields_t;
endpackage

// File: rtl/ldinc_ctrl.sv
module ldinc_ctrl
  import ldinc_pkg::*;
#(
  parameter logic [5:0] OP_LOAD     = 6'h23,
  parameter logic [5:0] OP_STORE    = 6'h2B,
  parameter logic [5:0] OP_LOAD_PI  = 6'h33,
  parameter logic [5:0] OP_STORE_PI = 6'h3B
) (
  input  logic       instrValid,
  input  logic [5:0] opcode,
  output ctlStrobe_t ctl
);
  always_comb begin
    ctl = '0;
    if (instrValid) begin
      unique case (opcode)
        OP_LOAD:     ctl.regWrite = 1'b1;
        OP_STORE:    ctl.memWrite = 1'b1;
        OP_LOAD_PI:  begin ctl.regWrite = 1'b1; ctl.baseWrite = 1'b1; end
        OP_STORE_PI: begin ctl.memWrite = 1'b1; ctl.baseWrite = 1'b1; end
        default:     ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/ldinc_regfile.sv
module ldinc_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   rdAddr1,
  output logic [DATA_W-1:0] rdData1,
  input  logic [RA_W-1:0]   rdAddr2,
  output logic [DATA_W-1:0] rdData2,
  input  logic [RA_W-1:0]   rdAddr3,
  output logic [DATA_W-1:0] rdData3,
  input  logic              wrEn1,
  input  logic [RA_W-1:0]   wrAddr1,
  input  logic [DATA_W-1:0] wrData1,
  input  logic              wrEn2,     // destination is rdAddr1
  input  logic [DATA_W-1:0] wrData2
);
  logic [REG_CNT-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      if (wrEn2 && rdAddr1 != '0) regs[rdAddr1] <= wrData2;
      // port 1 is applied last so it wins on a shared destination
      if (wrEn1 && wrAddr1 != '0) regs[wrAddr1] <= wrData1;
    end
  end

  assign rdData1 = (rdAddr1 == '0) ? '0 : regs[rdAddr1];
  assign rdData2 = (rdAddr2 == '0) ? '0 : regs[rdAddr2];
  assign rdData3 = (rdAddr3 == '0) ? '0 : regs[rdAddr3];
endmodule

// File: rtl/ldinc_datamem.sv
module ldinc_datamem #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  localparam int MA_W     = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              preWrEn,
  input  logic [MA_W-1:0]   preWrAddr,
  input  logic [DATA_W-1:0] preWrData,
  input  logic              wrEn,
  input  logic [MA_W-1:0]   accAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [MA_W-1:0]   dbgAddr,
  output logic [DATA_W-1:0] dbgData
);
  logic [DATA_W-1:0] mem [MEM_WORDS];

  always_ff @(posedge clk) begin
    if (preWrEn)   mem[preWrAddr] <= preWrData;
    else if (wrEn) mem[accAddr]   <= wrData;
  end

  assign rdData  = mem[accAddr];
  assign dbgData = mem[dbgAddr];
endmodule

// File: rtl/ldinc_datapath.sv
module ldinc_datapath
  import ldinc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_CNT   = 32,
  parameter int MEM_WORDS = 64,
  parameter int STRIDE    = 4,
  localparam int RA_W     = $clog2(REG_CNT),
  localparam int MA_W     = $clog2(MEM_WORDS),
  localparam int OFF_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instrWord,
  input  ctlStrobe_t        ctl,
  input  logic              preWrEn,
  input  logic [MA_W-1:0]   preWrAddr,
  input  logic [DATA_W-1:0] preWrData,
  input  logic [RA_W-1:0]   dbgRegAddr,
  output logic [DATA_W-1:0] dbgRegData,
  input  logic [MA_W-1:0]   dbgMemAddr,
  output logic [DATA_W-1:0] dbgMemData,
  output logic [DATA_W-1:0] rsVal,
  output logic [DATA_W-1:0] incData
);
  instrFields_t fields;
  logic [DATA_W-1:0] rtVal, offExt, effAddr, memRdData;
  logic [MA_W-1:0]   wordIdx;

  assign fields  = instrFields_t'(instrWord);
  assign offExt  = {{(DATA_W-OFF_W){fields.offset[OFF_W-1]}}, fields.offset};
  assign effAddr = rsVal + offExt;                 // address adder
  assign wordIdx = effAddr[2 +: MA_W];
  assign incData = rsVal + DATA_W'(STRIDE);        // base incrementer

  ldinc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) regfile_i (
    .clk     (clk),
    .rst     (rst),
    .rdAddr1 (fields.rs[RA_W-1:0]),
    .rdData1 (rsVal),
    .rdAddr2 (fields.rt[RA_W-1:0]),
    .rdData2 (rtVal),
    .rdAddr3 (dbgRegAddr),
    .rdData3 (dbgRegData),
    .wrEn1   (ctl.regWrite),
    .wrAddr1 (fields.rt[RA_W-1:0]),
    .wrData1 (memRdData),
    .wrEn2   (ctl.baseWrite),
    .wrData2 (incData)
  );

  ldinc_datamem #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) datamem_i (
    .clk       (clk),
    .preWrEn   (preWrEn),
    .preWrAddr (preWrAddr),
    .preWrData (preWrData),
    .wrEn      (ctl.memWrite),
    .accAddr   (wordIdx),
    .wrData    (rtVal),
    .rdData    (memRdData),
    .dbgAddr   (dbgMemAddr),
    .dbgData   (dbgMemData)
  );
endmodule

// File: rtl/ldinc_core.sv
module ldinc_core
  import ldinc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int STRIDE    = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         instrValid,
  input  logic [31:0]                  instrWord,
  input  logic                         preWrEn,
  input  logic [$clog2(MEM_WORDS)-1:0] preWrAddr,
  input  logic [DATA_W-1:0]            preWrData,
  input  logic [4:0]                   dbgRegAddr,
  output logic [DATA_W-1:0]            dbgRegData,
  input  logic [$clog2(MEM_WORDS)-1:0] dbgMemAddr,
  output logic [DATA_W-1:0]            dbgMemData
);
  ctlStrobe_t        ctl;
  logic [DATA_W-1:0] rsVal, incData;

  ldinc_ctrl ctrl_i (
    .instrValid (instrValid),
    .opcode     (instrWord[31:26]),
    .ctl        (ctl)
  );

  ldinc_datapath #(
    .DATA_W(DATA_W), .REG_CNT(32), .MEM_WORDS(MEM_WORDS), .STRIDE(STRIDE)
  ) datapath_i (
    .clk        (clk),
    .rst        (rst),
    .instrWord  (instrWord),
    .ctl        (ctl),
    .preWrEn    (preWrEn),
    .preWrAddr  (preWrAddr),
    .preWrData  (preWrData),
    .dbgRegAddr (dbgRegAddr),
    .dbgRegData (dbgRegData),
    .dbgMemAddr (dbgMemAddr),
    .dbgMemData (dbgMemData),
    .rsVal      (rsVal),
    .incData    (incData)
  );
endmodule

// File: rtl/ldinc_chk.sv
module ldinc_chk
  import ldinc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MA_W   = 6,
  parameter int STRIDE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              instrValid,
  input logic              preWrEn,
  input ctlStrobe_t        ctl,
  input logic [DATA_W-1:0] rsVal,
  input logic [DATA_W-1:0] incData,
  input logic [4:0]        dbgRegAddr,
  input logic [DATA_W-1:0] dbgRegData,
  input logic [MA_W-1:0]   dbgMemAddr,
  input logic [DATA_W-1:0] dbgMemData
);
  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> dbgRegData == '0); // R1
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> (ctl == '0)); // R9
  AST_STORE_NO_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> !ctl.regWrite); // R5
  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.baseWrite |-> incData == rsVal + DATA_W'(STRIDE)); // R4
  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (rst)
    dbgRegAddr == '0 |-> dbgRegData == '0); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!instrValid && !preWrEn) |=> ($stable(dbgMemAddr) -> $stable(dbgMemData))); // R9
endmodule

bind ldinc_core ldinc_chk #(
  .DATA_W(DATA_W), .MA_W($clog2(MEM_WORDS)), .STRIDE(STRIDE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .instrValid (instrValid),
  .preWrEn    (preWrEn),
  .ctl        (ctl),
  .rsVal      (rsVal),
  .incData    (incData),
  .dbgRegAddr (dbgRegAddr),
  .dbgRegData (dbgRegData),
  .dbgMemAddr (dbgMemAddr),
  .dbgMemData (dbgMemData)
);

// File: tb/ldinc_core_tb_top.sv
module ldinc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam logic [5:0] OP_LD = 6'h23, OP_ST = 6'h2B, OP_LDI = 6'h33, OP_STI = 6'h3B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        preWrEn = 1'b0;
  logic [5:0]  preWrAddr = '0;
  logic [31:0] preWrData = '0;
  logic [4:0]  dbgRegAddr = '0;
  logic [31:0] dbgRegData;
  logic [5:0]  dbgMemAddr = '0;
  logic [31:0] dbgMemData;

  logic [31:0] regM [32];
  logic [31:0] memM [MEM_WORDS];
  int vecCnt = 0, errCnt = 0, cycles = 0;
  bit done = 1'b0;

  ldinc_core dut_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .preWrEn(preWrEn), .preWrAddr(preWrAddr), .preWrData(preWrData),
    .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errCnt = errCnt + 1;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  task automatic compareState(input string tag, input bit withMem);
    for (int r = 0; r < 32; r++) begin
      dbgRegAddr = 5'(r);
      #1;
      vecCnt++;
      if (dbgRegData !== regM[r]) begin
        errCnt++;
        $display("FAIL %s reg %0d got %h exp %h", tag, r, dbgRegData, regM[r]);
      end
    end
    if (withMem) begin
      for (int m = 0; m < MEM_WORDS; m++) begin
        dbgMemAddr = 6'(m);
        #1;
        vecCnt++;
        if (dbgMemData !== memM[m]) begin
          errCnt++;
          $display("FAIL %s mem %0d got %h exp %h", tag, m, dbgMemData, memM[m]);
        end
      end
    end
  endtask

  // Model from requirements R2..R10, then drive one instruction and compare.
  task automatic issue(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                       input logic [15:0] off, input bit valid, input string tag);
    logic [31:0] rsv, rtv, ea, ld;
    logic [5:0]  idx;
    rsv = regM[rs];
    rtv = regM[rt];
    ea  = rsv + {{16{off[15]}}, off};
    idx = ea[7:2];
    ld  = memM[idx];
    if (valid) begin
      if (op == OP_ST || op == OP_STI) memM[idx] = rtv;
      if ((op == OP_LDI || op == OP_STI) && rs != 0) regM[rs] = rsv + 32'd4;
      if ((op == OP_LD || op == OP_LDI) && rt != 0) regM[rt] = ld;
    end
    @(negedge clk);
    instrWord  = {op, rs, rt, off};
    instrValid = valid;
    @(negedge clk);
    instrValid = 1'b0;
    compareState(tag, 1'b1);
  endtask

  initial begin
    string tag;
    for (int r = 0; r < 32; r++) regM[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compareState("R1", 1'b0);

    for (int m = 0; m < MEM_WORDS; m++) begin
      memM[m] = 32'(m) * 32'h9E3779B9 + 32'h0000_0100;
      @(negedge clk);
      preWrEn = 1'b1; preWrAddr = 6'(m); preWrData = memM[m];
    end
    @(negedge clk);
    preWrEn = 1'b0;

    // fill registers with loads from base r0
    for (int r = 1; r < 32; r++) issue(OP_LD, 5'd0, 5'(r), 16'(r * 4), 1'b1, "R2");
    issue(OP_LD, 5'd3, 5'd7, 16'h0008, 1'b1, "R10");
    issue(OP_ST, 5'd7, 5'd3, 16'h0010, 1'b1, "R10");

    begin
      logic [5:0]  ops  [4] = '{OP_LD, OP_ST, OP_LDI, OP_STI};
      logic [4:0]  regs [4] = '{5'd0, 5'd1, 5'd5, 5'd31};
      logic [15:0] offs [6] = '{16'h0000, 16'h0004, 16'hFFFC, 16'hFFF8, 16'h0006, 16'h8000};
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int f = 0; f < 6; f++) begin
              if (ops[o] == OP_LD)       tag = "R2";
              else if (ops[o] == OP_ST)  tag = "R3";
              else if (ops[o] == OP_STI) tag = "R5";
              else if (regs[a] == regs[b]) tag = "R7";
              else                       tag = "R4";
              if (regs[a] == 0 || regs[b] == 0) tag = "R8";
              else if (f >= 2)           tag = "R6";
              issue(ops[o], regs[a], regs[b], offs[f], 1'b1, tag);
            end
    end

    for (int op = 0; op < 64; op++) begin
      if (6'(op) != OP_LD && 6'(op) != OP_ST && 6'(op) != OP_LDI && 6'(op) != OP_STI)
        issue(6'(op), 5'd2, 5'd9, 16'h0004, 1'b1, "R9");
    end
    issue(OP_LDI, 5'd4, 5'd6, 16'h0000, 1'b0, "R9");
    issue(OP_STI, 5'd4, 5'd6, 16'h0000, 1'b0, "R9");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 32; r++) regM[r] = '0;
    compareState("R1", 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule